// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the protocol core of a byte-addressed serial memory that sits on a two-wire bus. It takes clock-domain samples of the bus clock and data lines together with one-cycle strobes that flag bus START and STOP events, and produces a single open-drain enable that pulls the data line low. It decodes the select byte, keeps the word address counter, and carries out byte writes, page writes, current-address reads, random reads and sequential reads against an internal synchronous RAM.

The capacity is a parameter from 128 to 2048 bytes. As the capacity grows, the chip-enable positions of the select byte are used as upper memory address bits and are no longer compared with the pins. A write-protect input blocks data writes. After a write transaction the engine enters a timed busy interval, during which it ignores the bus. This lets a master find the end of the interval by polling for an acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: A select byte is accepted when bits 7..4 equal 1010b and every chip-enable position (bits 3..1, compared with chipEn[2:0]) that is not used as an address bit matches its pin. An accepted select is acknowledged by pulling SDA low in the 9th bit slot. A rejected select gets no acknowledge, and SDA stays released until the next START.
- R2: Bit 1 of the select byte acts as address bit 8 when the capacity is at least 512 bytes. Bit 2 acts as address bit 9 from 1024 bytes, and bit 3 acts as address bit 10 at 2048 bytes. These positions are not compared with the pins. Bit 0 is the direction bit: 1 means read and 0 means write.
- R3: After a write select, the address byte is acknowledged. Each acknowledged data byte is stored at the counter, and then only the low 4 bits of the counter advance, so the counter wraps within its 16-byte page.
- R4: When writeCtl is high at the end of the address byte, the select and address bytes are still acknowledged. Every data byte then gets no acknowledge, and the memory is left unchanged.
- R5: A STOP that follows at least one stored data byte starts a busy interval of WR_CYCLES clocks. During this interval the engine never acknowledges, not even its own select byte, and START is ignored.
- R6: A random read is a write select, an address byte, a repeated START and a read select. It returns the byte at that address.
- R7: A read select with no address byte returns the byte at the counter, with the upper bits taken from the select byte. Reads work the same whatever the level of writeCtl.
- R8: In a read, a master acknowledge makes the engine send the next byte. The counter advances by one after every byte sent and wraps from the last location to 0.
- R9: A master no-acknowledge after a read byte ends the transfer. SDA then stays released, whatever clocks follow, until the next START.
- R10: A repeated START at any bit position drops the partial byte and restarts select decoding. A partially received data byte is never written.
- R11: Read data is sent MSB first. Each bit changes only after SCL falls, and SDA is released during the master's acknowledge slot.
- R12: After reset, sdaOe is low and the engine waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised bus clock sample |
| sdaIn | input | 1 | Synchronised bus data sample (wired line level) |
| startDet | input | 1 | One-cycle strobe: START or repeated START seen |
| stopDet | input | 1 | One-cycle strobe: STOP seen |
| chipEn | input | 3 | Chip-enable pins compared with select bits 3..1 |
| writeCtl | input | 1 | High blocks data writes |
| sdaOe | output | 1 | High pulls the data line low |

## Verification
Two kinds of event can land in the same bus window. A repeated START can arrive while a data byte is half shifted in. A select byte can arrive while the write-busy timer is still running. The bench triggers the first by cutting a data byte off after four bits and issuing a read select. It then checks that the select is acknowledged and that the stored byte is the old value. The bench triggers the second by polling right after a committed write, where it expects no acknowledge, and polling again after the interval, where it expects an acknowledge. A full sweep of all 128 select values at a 512-byte capacity compares every acknowledge against the decode rule worked out in the bench.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  typedef struct packed {
    logic shift;    // take one bus bit into the shift register
    logic setSel;   // latch upper address bits from the select byte
    logic setAddr;  // load the word address from the address byte
    logic memWr;    // store shift register at the counter
    logic incPage;  // advance low 4 counter bits only
    logic loadRd;   // load read byte, advance full counter
  } dpStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_dpath.sv
`timescale 1ns/1ps
module eep_dpath
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       sdaIn,
  output logic [7:0] byteVal,
  output logic       rdMsb
);
  localparam int ADDR_W = $clog2(MEM_BYTES);

  logic [7:0]        mem [MEM_BYTES];
  logic [7:0]        memQ;
  logic [7:0]        shReg;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addrFromByte;
  logic [ADDR_W-1:0] addrFromSel;

  if (ADDR_W > 8) begin : g_upper
    logic [ADDR_W-9:0] selUp;
    always_ff @(posedge clk) begin
      if (!rstN)           selUp <= '0;
      else if (stb.setSel) selUp <= shReg[ADDR_W-8:1];
    end
    assign addrFromByte = {selUp, shReg};
    assign addrFromSel  = {shReg[ADDR_W-8:1], addr[7:0]};
  end else begin : g_flat
    assign addrFromByte = shReg[ADDR_W-1:0];
    assign addrFromSel  = addr;
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[addr] <= shReg;
    memQ <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      addr  <= '0;
    end else begin
      if (stb.shift)   shReg <= {shReg[6:0], sdaIn};
      if (stb.loadRd)  shReg <= memQ;
      if (stb.setSel)  addr  <= addrFromSel;
      if (stb.setAddr) addr  <= addrFromByte;
      if (stb.incPage) addr  <= {addr[ADDR_W-1:4], addr[3:0] + 4'd1};
      if (stb.loadRd)  addr  <= addr + 1'b1;
    end
  end

  assign byteVal = shReg;
  assign rdMsb   = memQ[7];

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRd && addr == {ADDR_W{1'b1}}) |=> (addr == '0)); // R8
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb.incPage |=> $stable(addr[ADDR_W-1:4])); // R3
endmodule

// File: rtl/eep_ctrl.sv
`timescale 1ns/1ps
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [2:0] chipEn,
  input  logic       writeCtl,
  input  logic [7:0] byteVal,
  input  logic       rdMsb,
  output dpStrobe_t  stb,
  output logic       sdaOe
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] CE_MASK = {(ADDR_W < 11), (ADDR_W < 10), (ADDR_W < 9)};

  busState_t  state, nxtState, nxt;
  logic [3:0] bitCnt;
  logic       inAck, sclPrev, wcHold, wrote, busy, ackNow;
  logic [CNT_W-1:0] busyCnt;
  logic       sclRise, sclFall, byteEnd, selMatch, live;

  assign sclRise  = sclIn & ~sclPrev;
  assign sclFall  = ~sclIn & sclPrev;
  assign live     = !busy && !startDet && !stopDet;
  assign byteEnd  = sclFall && !inAck && bitCnt == 4'd8 && state != ST_IDLE;
  assign selMatch = (byteVal[7:4] == DEV_TYPE) &&
                    (((byteVal[3:1] ^ chipEn) & CE_MASK) == 3'b000);

  always_comb begin
    stb    = '0;
    ackNow = 1'b0;
    nxt    = ST_IDLE;
    if (live) begin
      if (sclRise && !inAck && state != ST_IDLE && bitCnt != 4'd8) stb.shift = 1'b1;
      if (byteEnd) begin
        unique case (state)
          ST_SEL: if (selMatch) begin
            ackNow     = 1'b1;
            stb.setSel = 1'b1;
            nxt        = byteVal[0] ? ST_RDATA : ST_ADDR;
          end
          ST_ADDR: begin
            ackNow      = 1'b1;
            stb.setAddr = 1'b1;
            nxt         = ST_WDATA;
          end
          ST_WDATA: begin
            nxt = ST_WDATA;
            if (!wcHold) begin
              ackNow      = 1'b1;
              stb.memWr   = 1'b1;
              stb.incPage = 1'b1;
            end
          end
          ST_RDATA: nxt = ST_RDATA;
          default:  nxt = ST_IDLE;
        endcase
      end
      if (sclFall && inAck && nxtState == ST_RDATA) stb.loadRd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev  <= 1'b1;
      state    <= ST_IDLE;
      nxtState <= ST_IDLE;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      sdaOe    <= 1'b0;
      wcHold   <= 1'b0;
      wrote    <= 1'b0;
      busy     <= 1'b0;
      busyCnt  <= '0;
    end else begin
      sclPrev <= sclIn;
      if (busy) begin
        state   <= ST_IDLE;
        sdaOe   <= 1'b0;
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == CNT_W'(1)) busy <= 1'b0;
      end else if (startDet) begin
        state  <= ST_SEL;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaOe  <= 1'b0;
        wrote  <= 1'b0;
        if (wrote) begin
          busy    <= 1'b1;
          busyCnt <= CNT_W'(WR_CYCLES);
        end
      end else begin
        if (stb.shift) bitCnt <= bitCnt + 4'd1;
        if (byteEnd) begin
          inAck    <= 1'b1;
          sdaOe    <= ackNow;
          nxtState <= nxt;
          if (state == ST_ADDR) wcHold <= writeCtl;
          if (stb.memWr) wrote <= 1'b1;
        end
        if (sclRise && inAck && state == ST_RDATA && sdaIn) nxtState <= ST_IDLE;
        if (sclFall && inAck) begin
          inAck  <= 1'b0;
          bitCnt <= '0;
          state  <= nxtState;
          sdaOe  <= stb.loadRd ? ~rdMsb : 1'b0;
        end else if (sclFall && state == ST_RDATA && !inAck &&
                     bitCnt != 4'd0 && bitCnt != 4'd8) begin
          sdaOe <= ~byteVal[7];
        end
      end
    end
  end

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R9
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startDet && !stopDet) |=> $stable(sdaOe)); // R11
  AST_WC_DATA_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (live && byteEnd && state == ST_WDATA && wcHold) |=> !sdaOe); // R4
endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [2:0] chipEn,
  input  logic       writeCtl,
  output logic       sdaOe
);
  dpStrobe_t  stb;
  logic [7:0] byteVal;
  logic       rdMsb;

  eep_ctrl #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .startDet(startDet), .stopDet(stopDet), .chipEn(chipEn),
    .writeCtl(writeCtl), .byteVal(byteVal), .rdMsb(rdMsb),
    .stb(stb), .sdaOe(sdaOe)
  );

  eep_dpath #(.MEM_BYTES(MEM_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaIn(sdaIn),
    .byteVal(byteVal), .rdMsb(rdMsb)
  );
endmodule

// File: tb/i2c_mem_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;
  localparam int MEM_BYTES = 512;
  localparam int WR_CYCLES = 300;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, scl = 1'b1, sdaM = 1'b1, startP = 1'b0, stopP = 1'b0;
  logic writeCtl = 1'b0;
  logic [2:0] chipEn = 3'b101;
  logic sdaOe, sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_mem_slave #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .startDet(startP), .stopDet(stopP), .chipEn(chipEn),
    .writeCtl(writeCtl), .sdaOe(sdaOe)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [7:0] model [MEM_BYTES];

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tk(2); scl = 1'b1; tk(4);
    sdaM = 1'b0; startP = 1'b1; tk(1); startP = 1'b0; tk(3);
    scl = 1'b0; tk(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tk(2); scl = 1'b1; tk(4);
    sdaM = 1'b1; stopP = 1'b1; tk(1); stopP = 1'b0; tk(4);
  endtask

  task automatic sendBit(logic b);
    sdaM = b; tk(2); scl = 1'b1; tk(4); scl = 1'b0; tk(2);
  endtask

  task automatic sendByte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tk(2); scl = 1'b1; tk(2);
    acked = ~sdaLine;
    tk(2); scl = 1'b0; tk(2);
  endtask

  task automatic recvByte(logic mAck, output logic [7:0] b, output logic oeSlot);
    for (int i = 0; i < 8; i++) begin
      tk(2); scl = 1'b1; tk(2); b = {b[6:0], sdaLine}; tk(2); scl = 1'b0;
    end
    sdaM = mAck ? 1'b0 : 1'b1; tk(2); scl = 1'b1; tk(2);
    oeSlot = sdaOe;
    tk(2); scl = 1'b0; tk(1); sdaM = 1'b1; tk(1);
  endtask

  function automatic logic [7:0] selW(logic [8:0] a);
    return {4'b1010, 2'b10, a[8], 1'b0};
  endfunction

  task automatic wrPage(logic [8:0] a, int n, logic [7:0] base, string tag);
    logic ak;
    busStart();
    sendByte(selW(a), ak);   chk(ak, 1, {tag, " select ack"});
    sendByte(a[7:0], ak);    chk(ak, 1, {tag, " address ack"});
    for (int i = 0; i < n; i++) begin
      logic [3:0] lo;
      lo = a[3:0] + 4'(i);
      sendByte(base + 8'(i), ak);
      chk(ak, 1, {tag, " data ack"});
      model[{a[8:4], lo}] = base + 8'(i);
    end
    busStop();
    tk(WR_CYCLES + 20);
  endtask

  task automatic rdSeq(logic [8:0] a, int n, string tag);
    logic ak, oe;
    logic [7:0] d;
    busStart();
    sendByte(selW(a), ak);          chk(ak, 1, {tag, " select ack"});
    sendByte(a[7:0], ak);           chk(ak, 1, {tag, " address ack"});
    busStart();
    sendByte(selW(a) | 8'h01, ak);  chk(ak, 1, {tag, " read select ack"});
    for (int i = 0; i < n; i++) begin
      logic [8:0] p;
      p = a + 9'(i);
      recvByte(i != n - 1, d, oe);
      chk(d, model[p], {tag, " read data"});
      chk(oe, 0, "R11 released in master ack slot");
    end
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic ak, oe;
    logic [7:0] d;
    tk(5);
    chk(sdaOe, 0, "R12 reset releases SDA");
    rstN = 1'b1; tk(5);
    chk(sdaOe, 0, "R12 idle after reset");

    // R1 R2: sweep of every select value in write direction
    for (int s = 0; s < 128; s++) begin
      logic [6:0] sv;
      logic expA;
      sv = 7'(s);
      expA = (sv[6:3] == 4'hA) && (sv[2:1] == 2'b10);
      busStart();
      sendByte({sv, 1'b0}, ak);
      chk(ak, expA, "R1 R2 select decode");
      busStop();
    end

    // R3 byte write, R5 busy polling
    busStart();
    sendByte(selW(9'h1A5), ak); chk(ak, 1, "R3 select");
    sendByte(8'hA5, ak);        chk(ak, 1, "R3 address");
    sendByte(8'h3C, ak);        chk(ak, 1, "R3 data");
    model[9'h1A5] = 8'h3C;
    busStop();
    busStart();
    sendByte(selW(9'h1A5), ak); chk(ak, 0, "R5 no ack while busy");
    chk(sdaOe, 0, "R5 SDA released while busy");
    busStop();
    tk(WR_CYCLES + 20);
    busStart();
    sendByte(selW(9'h1A5), ak); chk(ak, 1, "R5 ack after busy");
    busStop();

    rdSeq(9'h1A5, 1, "R6 random read");

    // R3 page roll-over
    wrPage(9'h0F0, 16, 8'h10, "R3 full page");
    wrPage(9'h0FA, 10, 8'h40, "R3 page wrap");
    rdSeq(9'h0F0, 16, "R8 sequential page");

    // R4 write protect
    writeCtl = 1'b1;
    busStart();
    sendByte(selW(9'h0F5), ak); chk(ak, 1, "R4 select acked");
    sendByte(8'hF5, ak);        chk(ak, 1, "R4 address acked");
    sendByte(8'hEE, ak);        chk(ak, 0, "R4 data nacked");
    sendByte(8'hEF, ak);        chk(ak, 0, "R4 second data nacked");
    busStop();
    rdSeq(9'h0F5, 2, "R4 R7 unchanged under writeCtl");
    writeCtl = 1'b0;

    // R8 wrap, R7 current address
    wrPage(9'h1F0, 16, 8'h80, "R8 fill top page");
    wrPage(9'h000, 3, 8'h5A, "R8 fill bottom");
    rdSeq(9'h1FE, 3, "R8 wrap to zero");
    busStart();
    sendByte(8'b1010_1001, ak); chk(ak, 1, "R7 current read select");
    recvByte(1'b0, d, oe);
    chk(d, model[9'h001], "R7 current address data");
    // R9 clocks after NACK get no drive
    for (int i = 0; i < 9; i++) begin
      sendBit(1'b1);
      chk(sdaOe, 0, "R9 released after master NACK");
    end
    busStop();

    // R10 repeated START mid data byte
    busStart();
    sendByte(selW(9'h002), ak); chk(ak, 1, "R10 select");
    sendByte(8'h02, ak);        chk(ak, 1, "R10 address");
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStart();
    sendByte(8'b1010_1001, ak); chk(ak, 1, "R10 select after abort");
    recvByte(1'b0, d, oe);
    chk(d, model[9'h002], "R10 partial byte not written");
    busStop();
    tk(20);
    busStart();
    sendByte(selW(9'h002), ak); chk(ak, 1, "R10 no busy after abort");
    busStop();

    finishRun();
  end
endmodule